// File: doc/BRIEF.md
# Integer Arithmetic and Logic Unit with Branch Comparison Flags

This block is the execute-stage arithmetic and logic unit of a small 32-bit RISC-V integer core. It is purely combinational: two operands and a 4-bit operation code from the instruction decoder go in, and a data result and a 3-bit comparison vector come out in the same cycle. It has no clock, no reset and no stored state. Integer multiply and divide are handled elsewhere, as are the register file and immediate generation.

The comparison vector does not follow the usual negative/zero/carry/overflow convention. It holds three facts about the operands: they are equal, the first is below the second as a signed value, or the first is below the second as an unsigned value. A downstream branch resolver takes each of the six conditional branch tests directly from one of these bits or from its inverse. The vector is computed on every evaluation, whatever operation is selected, so a branch can be resolved while the result path does something else.

Top module: `rv32_alu`

## Requirements
- R1: Operation code 0000 gives the sum opnd_a + opnd_b modulo 2^32.
- R2: Operation code 0001 gives the difference opnd_a - opnd_b modulo 2^32.
- R3: Operation codes 0010, 0011 and 0100 give the bitwise AND, OR and XOR of the operands.
- R4: Operation code 0101 shifts opnd_a left by opnd_b[4:0] and fills with zeros. Bits 31..5 of opnd_b have no effect on any of the three shifts.
- R5: Operation code 0110 shifts opnd_a right by opnd_b[4:0] and fills with zeros.
- R6: Operation code 0111 shifts opnd_a right by opnd_b[4:0] and fills with copies of opnd_a[31].
- R7: Operation code 1000 gives 1 when opnd_a < opnd_b as two's-complement values and 0 otherwise. Operation code 1001 does the same for the unsigned comparison.
- R8: Operation code 1010 passes opnd_b unchanged to alu_out.
- R9: Operation codes 1011 through 1111 give alu_out = 0.
- R10: cmp_flags[0] is 1 exactly when opnd_a equals opnd_b.
- R11: cmp_flags[1] is 1 exactly when opnd_a < opnd_b as signed 32-bit values.
- R12: cmp_flags[2] is 1 exactly when opnd_a < opnd_b as unsigned values. All three flags hold for every operation code, including the unused ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 32 | First operand; the value that is shifted |
| opnd_b | input | 32 | Second operand; its low 5 bits are the shift amount |
| op_code | input | 4 | Operation select from the decoder |
| alu_out | output | 32 | Result of the selected operation |
| cmp_flags | output | 3 | {unsigned less, signed less, equal}, equal in bit 0 |

## Verification
The hardest cases are the operand pairs where the signed and unsigned orderings disagree, because random operands produce them only about half the time and almost never near the sign boundary. The stimulus therefore pairs 0x80000000, 0x7FFFFFFF, 0xFFFFFFFF and 0 in both orders, and repeats each pair under unrelated operation codes to show that the flags do not depend on the selected operation. The shift cases put set bits above bit 4 of the shift amount and use amounts 0 and 31 on negative values, so that an arithmetic shift is told apart from a logical one.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int unsigned OP_W   = 4;
  localparam int unsigned FLAG_W = 3;
  localparam int unsigned FLAG_EQ  = 0;
  localparam int unsigned FLAG_LT  = 1;
  localparam int unsigned FLAG_LTU = 2;

  typedef enum logic [OP_W-1:0] {
    OP_ADD   = 4'd0,
    OP_SUB   = 4'd1,
    OP_AND   = 4'd2,
    OP_OR    = 4'd3,
    OP_XOR   = 4'd4,
    OP_SLL   = 4'd5,
    OP_SRL   = 4'd6,
    OP_SRA   = 4'd7,
    OP_SLT   = 4'd8,
    OP_SLTU  = 4'd9,
    OP_PASSB = 4'd10
  } alu_op_e;

  typedef enum logic [1:0] {
    BW_AND = 2'd0,
    BW_OR  = 2'd1,
    BW_XOR = 2'd2
  } bw_sel_e;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum
);
  logic [W-1:0] b_eff;
  logic [W:0]   full;

  function automatic logic [W:0] add_cin(input logic [W-1:0] x, input logic [W-1:0] y,
                                         input logic cin);
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
  endfunction

  always_comb begin
    b_eff = b ^ {W{sub}};
    full  = add_cin(a, b_eff, sub);
    sum   = full[W-1:0];
  end

  always_comb begin
    if (!$isunknown({a, b, sub}) && sub)
      AST_SUB_INVERTS: assert (sum + b == a); // R2
  end
endmodule

// File: rtl/alu_cmp.sv
module alu_cmp #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         eq,
  output logic         lt,
  output logic         ltu
);
  logic [W:0]   diff_ext;
  logic [W-1:0] diff;
  logic         no_borrow;
  logic         signs_differ;

  function automatic logic [W:0] sub_ext(input logic [W-1:0] x, input logic [W-1:0] y);
    return {1'b0, x} + {1'b0, ~y} + {{W{1'b0}}, 1'b1};
  endfunction

  always_comb begin
    diff_ext     = sub_ext(a, b);
    diff         = diff_ext[W-1:0];
    no_borrow    = diff_ext[W];
    signs_differ = a[W-1] ^ b[W-1];
    eq           = (diff == '0);
    ltu          = ~no_borrow;
    lt           = signs_differ ? a[W-1] : diff[W-1];
  end

  always_comb begin
    if (!$isunknown({a, b})) begin
      AST_EQ_EXCLUSIVE: assert (!(eq && (lt || ltu))); // R10
      AST_ORDER_SPLIT: assert ((lt == ltu) || signs_differ); // R11
    end
  end
endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
  parameter int unsigned W  = 32,
  parameter int unsigned SW = $clog2(W)
) (
  input  logic [W-1:0]  a,
  input  logic [SW-1:0] amt,
  input  logic          to_left,
  input  logic          arith,
  output logic [W-1:0]  y
);
  logic [W-1:0] stage [0:SW];
  logic         fill;
  logic [W-1:0] last;

  function automatic logic [W-1:0] flip(input logic [W-1:0] v);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = v[W-1-i];
    return r;
  endfunction

  always_comb begin
    fill     = arith & ~to_left & a[W-1];
    stage[0] = to_left ? flip(a) : a;
  end

  for (genvar s = 0; s < SW; s++) begin : g_stage
    localparam int unsigned STEP = 1 << s;
    assign stage[s+1] = amt[s] ? {{STEP{fill}}, stage[s][W-1:STEP]} : stage[s];
  end

  always_comb begin
    last = stage[SW];
    y    = to_left ? flip(last) : last;
  end

  always_comb begin
    if (!$isunknown({a, amt, to_left, arith})) begin
      if (to_left && amt != '0)
        AST_SLL_ZERO_LSB: assert (y[0] == 1'b0); // R4
      if (!to_left && arith)
        AST_SRA_KEEPS_SIGN: assert (y[W-1] == a[W-1]); // R6
      if (!to_left && !arith && amt != '0)
        AST_SRL_ZERO_MSB: assert (y[W-1] == 1'b0); // R5
    end
  end
endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0]     a,
  input  logic [W-1:0]     b,
  input  alu_pkg::bw_sel_e sel,
  output logic [W-1:0]     y
);
  import alu_pkg::*;

  always_comb begin
    unique case (sel)
      BW_AND:  y = a & b;
      BW_OR:   y = a | b;
      BW_XOR:  y = a ^ b;
      default: y = '0;
    endcase
  end

  always_comb begin
    if (!$isunknown({a, b, sel}) && sel == BW_XOR)
      AST_XOR_SPLIT: assert ((y | (a & b)) == (a | b)); // R3
  end
endmodule

// File: rtl/rv32_alu.sv
module rv32_alu #(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0]            opnd_a,
  input  logic [XLEN-1:0]            opnd_b,
  input  logic [alu_pkg::OP_W-1:0]   op_code,
  output logic [XLEN-1:0]            alu_out,
  output logic [alu_pkg::FLAG_W-1:0] cmp_flags
);
  import alu_pkg::*;

  localparam int unsigned SHW = $clog2(XLEN);

  logic              sub_sel;
  logic [XLEN-1:0]   arith_res;
  logic [XLEN-1:0]   shift_res;
  logic [XLEN-1:0]   logic_res;
  logic              shift_left;
  logic              shift_arith;
  logic [SHW-1:0]    shift_amt;
  bw_sel_e           bw_sel;
  logic              f_eq;
  logic              f_lt;
  logic              f_ltu;

  always_comb begin
    sub_sel     = (op_code == OP_SUB);
    shift_left  = (op_code == OP_SLL);
    shift_arith = (op_code == OP_SRA);
    shift_amt   = opnd_b[SHW-1:0];
    case (op_code)
      OP_OR:   bw_sel = BW_OR;
      OP_XOR:  bw_sel = BW_XOR;
      default: bw_sel = BW_AND;
    endcase
  end

  alu_addsub #(.W(XLEN)) u_addsub (
    .a   (opnd_a),
    .b   (opnd_b),
    .sub (sub_sel),
    .sum (arith_res)
  );

  alu_cmp #(.W(XLEN)) u_cmp (
    .a   (opnd_a),
    .b   (opnd_b),
    .eq  (f_eq),
    .lt  (f_lt),
    .ltu (f_ltu)
  );

  alu_shift #(.W(XLEN), .SW(SHW)) u_shift (
    .a       (opnd_a),
    .amt     (shift_amt),
    .to_left (shift_left),
    .arith   (shift_arith),
    .y       (shift_res)
  );

  alu_bitwise #(.W(XLEN)) u_bitwise (
    .a   (opnd_a),
    .b   (opnd_b),
    .sel (bw_sel),
    .y   (logic_res)
  );

  always_comb begin
    cmp_flags           = '0;
    cmp_flags[FLAG_EQ]  = f_eq;
    cmp_flags[FLAG_LT]  = f_lt;
    cmp_flags[FLAG_LTU] = f_ltu;
  end

  always_comb begin
    case (op_code)
      OP_ADD, OP_SUB:         alu_out = arith_res;
      OP_AND, OP_OR, OP_XOR:  alu_out = logic_res;
      OP_SLL, OP_SRL, OP_SRA: alu_out = shift_res;
      OP_SLT:                 alu_out = {{(XLEN-1){1'b0}}, f_lt};
      OP_SLTU:                alu_out = {{(XLEN-1){1'b0}}, f_ltu};
      OP_PASSB:               alu_out = opnd_b;
      default:                alu_out = '0;
    endcase
  end

  always_comb begin
    if (!$isunknown({opnd_a, opnd_b, op_code})) begin
      AST_EQ_MATCHES_OPERANDS: assert (cmp_flags[FLAG_EQ] == (opnd_a == opnd_b)); // R10
      if (op_code == OP_SLT)
        AST_SLT_BOOLEAN: assert (alu_out == {{(XLEN-1){1'b0}}, cmp_flags[FLAG_LT]}); // R7
      if (op_code == OP_SLTU)
        AST_SLTU_BOOLEAN: assert (alu_out == {{(XLEN-1){1'b0}}, cmp_flags[FLAG_LTU]}); // R7
      if (op_code > OP_PASSB)
        AST_UNUSED_ZERO: assert (alu_out == '0); // R9
      if (op_code == OP_PASSB)
        AST_PASS_B: assert (alu_out == opnd_b); // R8
      if (op_code == OP_ADD)
        AST_ADD_UNDO: assert (alu_out - opnd_b == opnd_a); // R1
    end
  end
endmodule

// File: tb/tb_rv32_alu.sv
module tb_rv32_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] opnd_a = '0;
  logic [31:0] opnd_b = '0;
  logic [3:0]  op_code = '0;
  logic [31:0] alu_out;
  logic [2:0]  cmp_flags;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  typedef struct {
    logic [3:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] res;
    logic [2:0]  flg;
  } item_t;

  item_t sb_q[$];

  always #10 clk = ~clk;

  rv32_alu dut (
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .op_code   (op_code),
    .alu_out   (alu_out),
    .cmp_flags (cmp_flags)
  );

  function automatic logic [31:0] model_res(input logic [3:0] op, input logic [31:0] a,
                                            input logic [31:0] b);
    logic [63:0] wide;
    int unsigned sh;
    sh = int'(b % 32);
    case (op)
      4'd0: begin wide = 64'(a) + 64'(b); return wide[31:0]; end
      4'd1: begin wide = 64'(a) + 64'(~b) + 64'd1; return wide[31:0]; end
      4'd2: return ~(~a | ~b);
      4'd3: return ~(~a & ~b);
      4'd4: return (a | b) & ~(a & b);
      4'd5: begin wide = 64'(a) << sh; return wide[31:0]; end
      4'd6: begin wide = {a, 32'd0} >> sh; return wide[63:32]; end
      4'd7: begin wide = {{32{a[31]}}, a} >> sh; return wide[31:0]; end
      4'd8: return (int'(a) < int'(b)) ? 32'd1 : 32'd0;
      4'd9: return (longint'(a) < longint'(b)) ? 32'd1 : 32'd0;
      4'd10: return b;
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [2:0] model_flags(input logic [31:0] a, input logic [31:0] b);
    logic [2:0] f;
    f[0] = (a == b);
    f[1] = (int'(a) < int'(b));
    f[2] = (longint'(a) < longint'(b));
    return f;
  endfunction

  function automatic string res_tag(input logic [3:0] op);
    case (op)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2, 4'd3, 4'd4: return "R3";
      4'd5: return "R4";
      4'd6: return "R5";
      4'd7: return "R6";
      4'd8, 4'd9: return "R7";
      4'd10: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic drive(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
    item_t it;
    @(negedge clk);
    opnd_a  = a;
    opnd_b  = b;
    op_code = op;
    it.op  = op;
    it.a   = a;
    it.b   = b;
    it.res = model_res(op, a, b);
    it.flg = model_flags(a, b);
    sb_q.push_back(it);
  endtask

  // monitor: pops one expected item per rising edge, half a period after drive
  initial begin
    forever begin
      @(posedge clk);
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        n_checks++;
        if (alu_out !== it.res) begin
          n_fail++;
          $display("FAIL %s op=%0d a=%h b=%h result actual=%h expected=%h",
                   res_tag(it.op), it.op, it.a, it.b, alu_out, it.res);
        end
        n_checks++;
        if (cmp_flags !== it.flg) begin
          n_fail++;
          $display("FAIL R10 R11 R12 op=%0d a=%h b=%h flags actual=%b expected=%b",
                   it.op, it.a, it.b, cmp_flags, it.flg);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] corner [0:7];
    corner[0] = 32'h0000_0000; corner[1] = 32'h0000_0001;
    corner[2] = 32'h7FFF_FFFF; corner[3] = 32'h8000_0000;
    corner[4] = 32'hFFFF_FFFF; corner[5] = 32'h8000_0001;
    corner[6] = 32'h1234_5678; corner[7] = 32'hFFFF_FFFE;

    repeat (2) @(posedge clk);
    rst_n = 1'b1;

    // idle inputs: all zero, ADD -> 0, equal flag only (R1 R10)
    drive(4'd0, 32'd0, 32'd0);

    // R1 wrap, R2 borrow through zero
    drive(4'd0, 32'hFFFF_FFFF, 32'd1);
    drive(4'd0, 32'h7FFF_FFFF, 32'h7FFF_FFFF);
    drive(4'd1, 32'd0, 32'd1);
    drive(4'd1, 32'h8000_0000, 32'd1);

    // R3 bitwise
    drive(4'd2, 32'hF0F0_A5A5, 32'hFF00_3C3C);
    drive(4'd3, 32'hF0F0_A5A5, 32'hFF00_3C3C);
    drive(4'd4, 32'hF0F0_A5A5, 32'hFF00_3C3C);

    // R4 R5 R6: amounts 0, 31, and upper amount bits set (0x25 -> 5)
    for (int op = 5; op <= 7; op++) begin
      drive(4'(op), 32'h8765_4321, 32'd0);
      drive(4'(op), 32'h8765_4321, 32'd31);
      drive(4'(op), 32'h8765_4321, 32'h0000_0025);
      drive(4'(op), 32'h8765_4321, 32'hFFFF_FFE3);
      drive(4'(op), 32'h4765_4321, 32'd7);
    end

    // R7 R11 R12: sign-boundary pairs in both orders, under every code
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++) begin
        drive(4'd8, corner[i], corner[j]);
        drive(4'd9, corner[i], corner[j]);
        drive(4'((i * 8 + j) % 16), corner[i], corner[j]);
      end

    // R8 pass-through, R9 unused codes give zero
    drive(4'd10, 32'h1357_9000, 32'hDEAD_B000);
    for (int op = 11; op <= 15; op++)
      drive(4'(op), 32'hFFFF_FFFF, 32'h0000_0001);

    // R12 flags independent of op code, equal operands under every code (R10)
    for (int op = 0; op < 16; op++) begin
      drive(4'(op), 32'h8000_0000, 32'h7FFF_FFFF);
      drive(4'(op), 32'hCAFE_0000, 32'hCAFE_0000);
    end

    // random sweep across all codes
    for (int k = 0; k < 400; k++)
      drive(4'($urandom_range(0, 15)), $urandom(), $urandom());

    while (sb_q.size() > 0) @(posedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule